// File: doc/BRIEF.md
# RGB Pixel Byte Serializer

This block takes one colour pixel per accepted input beat and sends it out over an 8-bit parallel data bus. In the four 16-bit packing modes, a pixel becomes a pair of bytes on two consecutive output cycles, so the output runs at half a pixel per clock. In raw mode, a 10-bit sample leaves in a single cycle. Its upper eight bits go on the byte bus and its lowest two bits go on a separate pair of extension lines, so the output runs at one pixel per clock.

The input is a valid/ready stream that carries 8-bit red, green and blue components together with a 10-bit raw value. A beat transfers on a rising clock edge where `in_valid` and `in_ready` are both high. The source must hold its beat stable until that edge. While a pixel's second byte is still waiting, `in_ready` is low. The output has no back-pressure: a byte appears in the cycle after its pixel is accepted, qualified by `out_valid` and tagged by `out_second`. The packing mode is a plain control input. It is read only on the edge that accepts a pixel.

Top module: `rgb_byte_serializer`

## Requirements
- R1: Mode code 0 (5-6-5 packing). The first byte is {R[7:3], G[7:5]} and the second byte is {G[4:2], B[7:3]}, with bit 7 as the MSB.
- R2: Mode code 1 (5-5-5 packing). The first byte is {1'b0, R[7:3], G[7:6]} and the second byte is {G[5:3], B[7:3]}.
- R3: Mode code 2 (4-4-4 with padding last). The first byte is {R[7:4], G[7:4]} and the second byte is {B[7:4], 4'h0}.
- R4: Mode code 3 (4-4-4 with padding first). The first byte is {4'h0, R[7:4]} and the second byte is {G[7:4], B[7:4]}.
- R5: Mode code 4 (raw). Each accepted beat produces one output cycle with `out_data` = raw[9:2], `out_lsb` = raw[1:0] and `out_second` = 0. The R, G and B inputs are ignored, and `in_ready` stays high so that a pixel can be accepted on every clock.
- R6: Mode codes 5, 6 and 7 produce exactly the same bytes as mode code 0.
- R7: In modes 0 to 3, the first byte appears in the cycle after acceptance with `out_second` = 0, and the second byte appears in the cycle after that with `out_second` = 1. `in_ready` is low while the first byte is shown and high while the second byte is shown. `out_lsb` is 0 in both cycles.
- R8: The mode is read only when a pixel is accepted. Changing `mode_i` between a pixel's first and second byte does not change that pixel's second byte.
- R9: In any cycle with no byte to send, `out_valid`, `out_second`, `out_data` and `out_lsb` are all 0.
- R10: A synchronous active-high `rst` discards any pending second byte. It also drives `out_valid`, `out_second`, `out_data` and `out_lsb` to 0 and leaves `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state; the output byte rate |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 3 | Packing mode code, read when a pixel is accepted |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Serializer can take a beat this cycle |
| in_r | input | 8 | Red component |
| in_g | input | 8 | Green component |
| in_b | input | 8 | Blue component |
| in_raw | input | 10 | Raw sample for mode 4 |
| out_data | output | 8 | Output byte |
| out_lsb | output | 2 | Low raw bits in mode 4, otherwise 0 |
| out_valid | output | 1 | `out_data` carries a byte this cycle |
| out_second | output | 1 | 1 on the second byte of a 16-bit pixel |

## Verification
The serializer's internal state is a pending flag plus one held byte, and any fault in them shows at the ports within two clocks of acceptance. A stuck pending flag either drops the second byte, visible as `out_valid` low one cycle early, or keeps `in_ready` low indefinitely. A wrong held byte corrupts `out_data` in the cycle flagged by `out_second`. A mode that is read again in the middle of a pixel alters only the second byte, which is why the bench switches `mode_i` between the two bytes. A pending flag that survives reset shows up as a stray second byte in the first cycle after reset.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int BYTE_W = 8;
  localparam int COMP_W = 8;

  typedef enum logic [2:0] {
    PK_565  = 3'd0,
    PK_555  = 3'd1,
    PK_444L = 3'd2,
    PK_444H = 3'd3,
    PK_RAW  = 3'd4
  } pack_mode_e;

  function automatic logic mode_is_raw(input logic [2:0] m);
    return m == PK_RAW;
  endfunction
endpackage

// File: rtl/pbs_packer.sv
module pbs_packer
  import pbs_pkg::*;
(
  input  logic [2:0]          mode_i,
  input  logic [COMP_W-1:0]   r_i,
  input  logic [COMP_W-1:0]   g_i,
  input  logic [COMP_W-1:0]   b_i,
  output logic [2*BYTE_W-1:0] pair_o
);
  // pair_o[15:8] leaves first, pair_o[7:0] second
  always_comb begin
    unique case (mode_i)
      PK_555:  pair_o = {1'b0, r_i[7:3], g_i[7:6], g_i[5:3], b_i[7:3]};
      PK_444L: pair_o = {r_i[7:4], g_i[7:4], b_i[7:4], 4'h0};
      PK_444H: pair_o = {4'h0, r_i[7:4], g_i[7:4], b_i[7:4]};
      default: pair_o = {r_i[7:3], g_i[7:5], g_i[4:2], b_i[7:3]};
    endcase
  end
endmodule

// File: rtl/pbs_sequencer.sv
module pbs_sequencer
  import pbs_pkg::*;
#(
  parameter int RAW_W = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2:0]             mode_i,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [2*BYTE_W-1:0]    pair_i,
  input  logic [RAW_W-1:0]       raw_i,
  output logic [BYTE_W-1:0]      out_data,
  output logic [RAW_W-BYTE_W-1:0] out_lsb,
  output logic                   out_valid,
  output logic                   out_second
);
  localparam int LSB_W = RAW_W - BYTE_W;

  logic              pending_q;
  logic [BYTE_W-1:0] hold_q;
  logic              accept;
  logic              raw_sel;

  assign in_ready = !pending_q;
  assign accept   = in_valid && in_ready;
  assign raw_sel  = mode_is_raw(mode_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q  <= 1'b0;
      hold_q     <= '0;
      out_data   <= '0;
      out_lsb    <= '0;
      out_valid  <= 1'b0;
      out_second <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_second <= 1'b0;
      if (raw_sel) begin
        out_data  <= raw_i[RAW_W-1 -: BYTE_W];
        out_lsb   <= raw_i[LSB_W-1:0];
        pending_q <= 1'b0;
      end else begin
        out_data  <= pair_i[2*BYTE_W-1 -: BYTE_W];
        out_lsb   <= '0;
        hold_q    <= pair_i[BYTE_W-1:0];
        pending_q <= 1'b1;
      end
    end else if (pending_q) begin
      out_data   <= hold_q;
      out_lsb    <= '0;
      out_valid  <= 1'b1;
      out_second <= 1'b1;
      pending_q  <= 1'b0;
    end else begin
      out_data   <= '0;
      out_lsb    <= '0;
      out_valid  <= 1'b0;
      out_second <= 1'b0;
    end
  end

  // R7: a 16-bit pixel shows its first byte next and blocks input
  p_first_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !mode_is_raw(mode_i)) |=> (out_valid && !out_second && !in_ready));

  // R7: the second byte follows immediately and reopens input
  p_second_follows_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_second && !in_ready) |=> (out_valid && out_second && in_ready && out_lsb == '0));

  // R8: the second byte is the one packed when the pixel was accepted
  p_second_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_second && !in_ready) |=> (out_data == $past(pair_i[BYTE_W-1:0], 2)));

  // R5: raw beats pass through in one cycle without blocking
  p_raw_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && mode_is_raw(mode_i)) |=>
      (out_valid && !out_second && in_ready &&
       {out_data, out_lsb} == $past(raw_i)));

  // R9: an idle output is all zero
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0 && out_lsb == '0 && !out_second));
endmodule

// File: rtl/rgb_byte_serializer.sv
module rgb_byte_serializer
  import pbs_pkg::*;
#(
  parameter int RAW_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2:0]              mode_i,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [COMP_W-1:0]       in_r,
  input  logic [COMP_W-1:0]       in_g,
  input  logic [COMP_W-1:0]       in_b,
  input  logic [RAW_W-1:0]        in_raw,
  output logic [BYTE_W-1:0]       out_data,
  output logic [RAW_W-BYTE_W-1:0] out_lsb,
  output logic                    out_valid,
  output logic                    out_second
);
  logic [2*BYTE_W-1:0] pair;

  pbs_packer u_packer (
    .mode_i (mode_i),
    .r_i    (in_r),
    .g_i    (in_g),
    .b_i    (in_b),
    .pair_o (pair)
  );

  pbs_sequencer #(.RAW_W(RAW_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .pair_i     (pair),
    .raw_i      (in_raw),
    .out_data   (out_data),
    .out_lsb    (out_lsb),
    .out_valid  (out_valid),
    .out_second (out_second)
  );
endmodule

// File: tb/tb_rgb_byte_serializer.sv
module tb_rgb_byte_serializer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_i = 3'd0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_r = '0, in_g = '0, in_b = '0;
  logic [9:0] in_raw = '0;
  logic [7:0] out_data;
  logic [1:0] out_lsb;
  logic       out_valid, out_second;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rgb_byte_serializer dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .in_valid(in_valid), .in_ready(in_ready),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_raw(in_raw),
    .out_data(out_data), .out_lsb(out_lsb), .out_valid(out_valid), .out_second(out_second)
  );

  // {mode, r, g, b, raw, first, second, lsb}
  localparam int NV = 14;
  localparam logic [54:0] VEC [NV] = '{
    {3'd0, 8'hA5, 8'h3C, 8'hE7, 10'h000, 8'hA1, 8'hFC, 2'b00},
    {3'd1, 8'hA5, 8'h3C, 8'hE7, 10'h000, 8'h50, 8'hFC, 2'b00},
    {3'd2, 8'hA5, 8'h3C, 8'hE7, 10'h000, 8'hA3, 8'hE0, 2'b00},
    {3'd3, 8'hA5, 8'h3C, 8'hE7, 10'h000, 8'h0A, 8'h3E, 2'b00},
    {3'd0, 8'h0F, 8'hFF, 8'h18, 10'h000, 8'h0F, 8'hE3, 2'b00},
    {3'd1, 8'h0F, 8'hFF, 8'h18, 10'h000, 8'h07, 8'hE3, 2'b00},
    {3'd2, 8'h0F, 8'hFF, 8'h18, 10'h000, 8'h0F, 8'h10, 2'b00},
    {3'd3, 8'h0F, 8'hFF, 8'h18, 10'h000, 8'h00, 8'hF1, 2'b00},
    {3'd6, 8'hA5, 8'h3C, 8'hE7, 10'h000, 8'hA1, 8'hFC, 2'b00},
    {3'd7, 8'h0F, 8'hFF, 8'h18, 10'h000, 8'h0F, 8'hE3, 2'b00},
    {3'd5, 8'h0F, 8'hFF, 8'h18, 10'h000, 8'h0F, 8'hE3, 2'b00},
    {3'd4, 8'hA5, 8'h3C, 8'hE7, 10'h2D6, 8'hB5, 8'h00, 2'b10},
    {3'd4, 8'h0F, 8'hFF, 8'h18, 10'h3FF, 8'hFF, 8'h00, 2'b11},
    {3'd4, 8'hFF, 8'hFF, 8'hFF, 10'h001, 8'h00, 8'h00, 2'b01}
  };

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "valid", 16'(out_valid), 16'd0);
    chk(req, "second", 16'(out_second), 16'd0);
    chk(req, "data", 16'(out_data), 16'd0);
    chk(req, "lsb", 16'(out_lsb), 16'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R10: state during and after reset
    repeat (3) @(negedge clk);
    chk_idle("R10");
    chk("R10", "ready", 16'(in_ready), 16'd1);
    rst = 1'b0;

    // table walk: R1..R6, R7, R9
    for (int i = 0; i < NV; i++) begin
      logic [2:0] m;
      logic [7:0] e1, e2;
      logic [1:0] el;
      m  = VEC[i][54:52];
      e1 = VEC[i][17:10];
      e2 = VEC[i][9:2];
      el = VEC[i][1:0];
      @(negedge clk);
      mode_i = m; in_r = VEC[i][51:44]; in_g = VEC[i][43:36];
      in_b = VEC[i][35:28]; in_raw = VEC[i][27:18]; in_valid = 1'b1;
      chk("R7", "ready idle", 16'(in_ready), 16'd1);
      @(negedge clk);
      in_valid = 1'b0;
      chk(req_of(m), "first data", 16'(out_data), 16'(e1));
      chk(req_of(m), "first lsb", 16'(out_lsb), 16'(el));
      chk("R7", "first valid", 16'(out_valid), 16'd1);
      chk("R7", "first flag", 16'(out_second), 16'd0);
      if (m != 3'd4) begin
        chk("R7", "ready first", 16'(in_ready), 16'd0);
        @(negedge clk);
        chk(req_of(m), "second data", 16'(out_data), 16'(e2));
        chk("R7", "second flag", 16'(out_second), 16'd1);
        chk("R7", "second lsb", 16'(out_lsb), 16'd0);
        chk("R7", "ready second", 16'(in_ready), 16'd1);
      end else begin
        chk("R5", "ready raw", 16'(in_ready), 16'd1);
      end
      @(negedge clk);
      chk_idle("R9");
    end

    // R8: mode switched between first and second byte
    @(negedge clk);
    mode_i = 3'd0; in_r = 8'hA5; in_g = 8'h3C; in_b = 8'hE7; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; mode_i = 3'd3;
    chk("R8", "first", 16'(out_data), 16'h00A1);
    @(negedge clk);
    chk("R8", "second", 16'(out_data), 16'h00FC);
    @(negedge clk);

    // R7: back-to-back 16-bit pixels with valid held high
    mode_i = 3'd2; in_r = 8'hA5; in_g = 8'h3C; in_b = 8'hE7; in_valid = 1'b1;
    @(negedge clk);
    chk("R7", "b2b first A", 16'(out_data), 16'h00A3);
    chk("R7", "b2b ready A1", 16'(in_ready), 16'd0);
    in_r = 8'h0F; in_g = 8'hFF; in_b = 8'h18;
    @(negedge clk);
    chk("R7", "b2b second A", 16'(out_data), 16'h00E0);
    chk("R7", "b2b ready A2", 16'(in_ready), 16'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", "b2b first B", 16'(out_data), 16'h000F);
    chk("R7", "b2b flag B", 16'(out_second), 16'd0);
    @(negedge clk);
    chk("R7", "b2b second B", 16'(out_data), 16'h0010);
    @(negedge clk);
    chk_idle("R9");

    // R5: raw burst, one pixel per clock
    mode_i = 3'd4; in_raw = 10'h100; in_valid = 1'b1;
    @(negedge clk);
    chk("R5", "burst 0", {out_data, out_lsb}, 10'h100);
    chk("R5", "burst ready", 16'(in_ready), 16'd1);
    in_raw = 10'h3FE;
    @(negedge clk);
    chk("R5", "burst 1", {out_data, out_lsb}, 10'h3FE);
    in_raw = 10'h003;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5", "burst 2", {out_data, out_lsb}, 10'h003);
    chk("R5", "burst flag", 16'(out_second), 16'd0);
    @(negedge clk);
    chk_idle("R9");

    // R10: reset while a second byte is pending
    mode_i = 3'd0; in_r = 8'hA5; in_g = 8'h3C; in_b = 8'hE7; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    chk("R10", "pre-reset first", 16'(out_data), 16'h00A1);
    @(negedge clk);
    rst = 1'b0;
    chk_idle("R10");
    chk("R10", "ready", 16'(in_ready), 16'd1);
    @(negedge clk);
    chk_idle("R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule